// File: doc/BRIEF.md
# Dual Time-Match Alarm with Shared Interrupt / Clock Output

This block watches the running clock and calendar and raises an event when the time matches a stored pattern. It holds two independent alarm slots. Each slot stores a value for seconds, minutes, hours, day-of-week, date, month and year, plus one enable bit per field. Fields whose enable bit is clear are ignored, so a slot can fire every minute, every Tuesday, or at one exact moment on one date. The current time arrives on an input bus together with a one-cycle pulse that marks each new second. A match is tested only on that pulse, so a matching second fires a slot once.

A firing slot sets a sticky flag that the host polls and clears with a per-slot clear pulse. A slot is either one-shot or repeating. A one-shot slot disarms itself when it fires. A repeating slot stays armed, which gives a periodic interrupt. A single registered, active-low output pin is shared by several functions, chosen by a mode input: the interrupt (the OR of all flags), one of three square waves derived from a 32768 Hz reference, or a constant inactive level.

Top module: `dual_alarm_irq`

## Requirements
- R1: After a synchronous reset, all alarm flags are 0, every slot is disarmed, and `irq_fout_n` is 1.
- R2: `cur_time` packs the fields as sec [5:0], min [11:6], hour [16:12], dow [19:17], date [24:20], month [28:25], year [35:29]. The mask bit order is sec 0, min 1, hour 2, dow 3, date 4, month 5, year 6. An armed slot fires when every field with its mask bit set equals the stored value. Fields with a clear mask bit are ignored.
- R3: Matching is tested only in a cycle where `sec_tick` is 1. A matching time with no tick sets no flag, and a tick with a mismatching enabled field sets no flag.
- R4: Each slot has its own flag, bit i of `alarm_flag`. Both flags can be set by the same tick.
- R5: A flag stays set until its `flag_clr` bit is pulsed, and it reads 0 in the cycle after the clear. When a clear and a firing of the same slot fall in the same cycle, the flag ends up set.
- R6: A slot written with `cfg_repeat`=0 disarms when it fires, and does not fire on later matches until it is written again with `cfg_arm`=1.
- R7: A slot written with `cfg_repeat`=1 stays armed and fires on every matching tick.
- R8: When `out_mode`=1 (interrupt), `irq_fout_n` is 0 in the cycle after any flag is 1, and 1 in the cycle after all flags are 0.
- R9: `xtal_in` is a 32768 Hz reference. When `out_mode`=4, the pin follows `xtal_in` delayed by one cycle. When `out_mode`=3, the pin is the reference divided by 8 (4096 Hz). When `out_mode`=2, the pin is the reference divided by 2^DIV_W (1 Hz at the default DIV_W of 15).
- R10: When `out_mode` is 0, or any of the unused codes 5 to 7, `irq_fout_n` is 1 one cycle later, whatever the flag state.
- R11: A slot written with `cfg_arm`=0 never sets its flag, even on a full match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse marking a new second on `cur_time` |
| cur_time | input | 36 | Packed current time and calendar fields |
| cfg_we | input | 1 | Write strobe for one alarm slot |
| cfg_sel | input | 1 | Index of the slot being written |
| cfg_time | input | 36 | Alarm field values, packed like `cur_time` |
| cfg_mask | input | 7 | Per-field match enables |
| cfg_arm | input | 1 | Arm bit written to the slot |
| cfg_repeat | input | 1 | 1 selects repeating mode, 0 selects one-shot |
| flag_clr | input | 2 | Per-slot flag clear pulses |
| out_mode | input | 3 | Pin function: 0 off, 1 interrupt, 2 1 Hz, 3 4096 Hz, 4 32768 Hz |
| xtal_in | input | 1 | 32768 Hz reference, synchronous to `clk` |
| alarm_flag | output | 2 | Sticky per-slot alarm flags |
| irq_fout_n | output | 1 | Shared active-low interrupt / frequency output |

## Verification
The bench holds a matching time on `cur_time` with no tick, and also ticks with a single enabled field off by one. A design that compared on every cycle, or that ignored one field's enable, would set a flag in one of these cases. It issues a clear in the same cycle as a repeating match, which a design that gave priority to the clear would lose. It re-presents a match to a fired one-shot slot, which a design that never disarmed would fire again. It checks the one-cycle lag of the pin behind the flags, and it counts square-wave rising edges over whole periods, so a wrong divider tap shows as a wrong edge count.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int TIME_W     = 36;

  typedef enum logic [2:0] {
    PIN_OFF  = 3'd0,
    PIN_IRQ  = 3'd1,
    PIN_1HZ  = 3'd2,
    PIN_4KHZ = 3'd3,
    PIN_32K  = 3'd4
  } pin_mode_e;

  // field order: sec, min, hour, dow, date, month, year
  function automatic int field_width(input int f);
    case (f)
      0: return 6;
      1: return 6;
      2: return 5;
      3: return 3;
      4: return 5;
      5: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic int field_lo(input int f);
    int acc;
    acc = 0;
    for (int k = 0; k < f; k++) acc += field_width(k);
    return acc;
  endfunction
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
  import dual_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sec_tick,
  input  logic [TIME_W-1:0]     cur_time,
  input  logic                  wr_en,
  input  logic [TIME_W-1:0]     wr_time,
  input  logic [NUM_FIELDS-1:0] wr_mask,
  input  logic                  wr_arm,
  input  logic                  wr_repeat,
  input  logic                  clr,
  output logic                  flag
);
  logic [TIME_W-1:0]     slot_time;
  logic [NUM_FIELDS-1:0] slot_mask;
  logic                  armed;
  logic                  repeat_mode;
  logic [NUM_FIELDS-1:0] field_ok;
  logic                  fire;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int LO = field_lo(f);
    localparam int W  = field_width(f);
    assign field_ok[f] = !slot_mask[f] ||
                         (cur_time[LO +: W] == slot_time[LO +: W]);
  end

  assign fire = sec_tick && armed && (&field_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_time   <= '0;
      slot_mask   <= '0;
      armed       <= 1'b0;
      repeat_mode <= 1'b0;
    end else if (wr_en) begin
      slot_time   <= wr_time;
      slot_mask   <= wr_mask;
      armed       <= wr_arm;
      repeat_mode <= wr_repeat;
    end else if (fire && !repeat_mode) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (fire) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int DIV_W   = 15,
  parameter int MID_BIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic xtal_in,
  output logic ref_q,
  output logic wave_mid,
  output logic wave_slow
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_q <= xtal_in;
      if (xtal_in && !ref_q) cnt <= cnt + 1'b1;
    end
  end

  assign wave_mid  = cnt[MID_BIT];
  assign wave_slow = cnt[DIV_W-1];
endmodule

// File: rtl/dual_alarm_irq.sv
module dual_alarm_irq
  import dual_alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int DIV_W      = 15,
  parameter int MID_BIT    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sec_tick,
  input  logic [TIME_W-1:0]     cur_time,
  input  logic                  cfg_we,
  input  logic [(NUM_ALARMS > 1 ? $clog2(NUM_ALARMS) : 1)-1:0] cfg_sel,
  input  logic [TIME_W-1:0]     cfg_time,
  input  logic [NUM_FIELDS-1:0] cfg_mask,
  input  logic                  cfg_arm,
  input  logic                  cfg_repeat,
  input  logic [NUM_ALARMS-1:0] flag_clr,
  input  logic [2:0]            out_mode,
  input  logic                  xtal_in,
  output logic [NUM_ALARMS-1:0] alarm_flag,
  output logic                  irq_fout_n
);
  localparam int SEL_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;

  logic ref_q, wave_mid, wave_slow;
  logic pin_next;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_slot
    alarm_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .sec_tick  (sec_tick),
      .cur_time  (cur_time),
      .wr_en     (cfg_we && (cfg_sel == SEL_W'(i))),
      .wr_time   (cfg_time),
      .wr_mask   (cfg_mask),
      .wr_arm    (cfg_arm),
      .wr_repeat (cfg_repeat),
      .clr       (flag_clr[i]),
      .flag      (alarm_flag[i])
    );
  end

  ref_divider #(.DIV_W(DIV_W), .MID_BIT(MID_BIT)) u_div (
    .clk       (clk),
    .rst       (rst),
    .xtal_in   (xtal_in),
    .ref_q     (ref_q),
    .wave_mid  (wave_mid),
    .wave_slow (wave_slow)
  );

  always_comb begin
    case (pin_mode_e'(out_mode))
      PIN_IRQ:  pin_next = ~(|alarm_flag);
      PIN_1HZ:  pin_next = wave_slow;
      PIN_4KHZ: pin_next = wave_mid;
      PIN_32K:  pin_next = xtal_in;
      default:  pin_next = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq_fout_n <= 1'b1;
    else     irq_fout_n <= pin_next;
  end

  // ref_q is the divider's edge-detect stage; the pin samples xtal directly
  logic unused_ok;
  assign unused_ok = ref_q;
endmodule

// File: rtl/dual_alarm_irq_checker.sv
module dual_alarm_irq_checker
  import dual_alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sec_tick,
  input logic [NUM_ALARMS-1:0] flag_clr,
  input logic [2:0]            out_mode,
  input logic                  xtal_in,
  input logic [NUM_ALARMS-1:0] alarm_flag,
  input logic                  irq_fout_n
);
  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    p_set_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_flag[i]) |-> $past(sec_tick));
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (alarm_flag[i] && !flag_clr[i]) |=> alarm_flag[i]);
    p_flag_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (alarm_flag[i] && flag_clr[i] && !sec_tick) |=> !alarm_flag[i]);
  end

  p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 3'd1 && (|alarm_flag)) |=> !irq_fout_n);
  p_irq_high_r8: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 3'd1 && !(|alarm_flag)) |=> irq_fout_n);
  p_fast_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 3'd4) |=> (irq_fout_n == $past(xtal_in)));
  p_off_high_r10: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 3'd0 || out_mode > 3'd4) |=> irq_fout_n);
endmodule

bind dual_alarm_irq dual_alarm_irq_checker #(.NUM_ALARMS(NUM_ALARMS)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .sec_tick   (sec_tick),
  .flag_clr   (flag_clr),
  .out_mode   (out_mode),
  .xtal_in    (xtal_in),
  .alarm_flag (alarm_flag),
  .irq_fout_n (irq_fout_n)
);

// File: tb/dual_alarm_irq_bench.sv
module dual_alarm_irq_bench;
  import dual_alarm_pkg::*;

  localparam int BENCH_DIV_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sec_tick = 1'b0;
  logic [TIME_W-1:0] cur_time = '0;
  logic              cfg_we = 1'b0;
  logic [0:0]        cfg_sel = '0;
  logic [TIME_W-1:0] cfg_time = '0;
  logic [6:0]        cfg_mask = '0;
  logic              cfg_arm = 1'b0;
  logic              cfg_repeat = 1'b0;
  logic [1:0]        flag_clr = '0;
  logic [2:0]        out_mode = 3'd0;
  logic              xtal_in = 1'b0;
  logic [1:0]        alarm_flag;
  logic              irq_fout_n;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  xtal_run = 0;
  logic xdiv = 1'b0;

  always #5 clk = ~clk;

  dual_alarm_irq #(.NUM_ALARMS(2), .DIV_W(BENCH_DIV_W), .MID_BIT(2)) u_dual_alarm_irq (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .cur_time(cur_time),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_time(cfg_time), .cfg_mask(cfg_mask),
    .cfg_arm(cfg_arm), .cfg_repeat(cfg_repeat), .flag_clr(flag_clr),
    .out_mode(out_mode), .xtal_in(xtal_in), .alarm_flag(alarm_flag),
    .irq_fout_n(irq_fout_n)
  );

  // reference: toggles every two clocks
  always @(negedge clk) begin
    if (xtal_run) begin
      xdiv <= ~xdiv;
      if (xdiv) xtal_in <= ~xtal_in;
    end
  end

  // scoreboard
  typedef struct {
    string req;
    int    kind;  // 0: flags, 1: pin, 2: value carried in exp/act
    int    exp;
    int    act;
  } item_t;
  item_t exp_q[$];
  event  chk_ev;

  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      item_t it;
      int    got;
      it = exp_q.pop_front();
      got = (it.kind == 0) ? int'(alarm_flag) :
            (it.kind == 1) ? int'(irq_fout_n) : it.act;
      checks++;
      if (got != it.exp) begin
        errors++;
        $display("FAIL %s: actual %0d expected %0d", it.req, got, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input int exp, input int act, input string req);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp; it.act = act;
    exp_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  function automatic logic [TIME_W-1:0] pack_time(int s, int mi, int h, int dw, int dt, int mo, int y);
    return {7'(y), 4'(mo), 5'(dt), 3'(dw), 5'(h), 6'(mi), 6'(s)};
  endfunction

  task automatic write_slot(input int sel, input logic [TIME_W-1:0] t,
                            input logic [6:0] m, input logic arm, input logic rpt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'(sel); cfg_time = t; cfg_mask = m;
    cfg_arm = arm; cfg_repeat = rpt;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input logic [TIME_W-1:0] t, input logic [1:0] clr);
    @(negedge clk);
    cur_time = t; sec_tick = 1'b1; flag_clr = clr;
    @(negedge clk);
    sec_tick = 1'b0; flag_clr = 2'b00;
  endtask

  task automatic clear(input logic [1:0] clr);
    @(negedge clk);
    flag_clr = clr;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rises(input int n, output int cnt);
    logic prev;
    cnt = 0;
    prev = irq_fout_n;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!prev && irq_fout_n) cnt++;
      prev = irq_fout_n;
    end
  endtask

  initial begin
    int   rises;
    int   mism;
    logic xs;
    logic [TIME_W-1:0] full_t;
    full_t = pack_time(0, 23, 5, 2, 21, 3, 26);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_item(0, 0, 0, "R1 flags after reset");
    expect_item(1, 1, 0, "R1 pin after reset");

    out_mode = 3'd1;
    // slot 0: every minute at sec 30, one-shot
    write_slot(0, pack_time(30, 0, 0, 0, 0, 0, 0), 7'b0000001, 1'b1, 1'b0);
    tick(pack_time(29, 5, 1, 1, 1, 1, 1), 2'b00);
    expect_item(0, 0, 0, "R3 tick with mismatched seconds");
    @(negedge clk);
    cur_time = pack_time(30, 5, 1, 1, 1, 1, 1);
    idle(3);
    expect_item(0, 0, 0, "R3 match held without tick");

    tick(pack_time(30, 5, 1, 1, 1, 1, 1), 2'b00);
    expect_item(0, 1, 0, "R2 seconds-only match fires slot 0");
    expect_item(1, 1, 0, "R8 pin lags flag by one cycle");
    idle(1);
    expect_item(1, 0, 0, "R8 pin low with flag set");

    clear(2'b01);
    expect_item(0, 0, 0, "R5 clear pulse drops flag");
    idle(1);
    expect_item(1, 1, 0, "R8 pin high after flags clear");

    tick(pack_time(30, 6, 1, 1, 1, 1, 1), 2'b00);
    expect_item(0, 0, 0, "R6 one-shot slot disarmed after firing");

    // slot 1: every Tuesday (dow 2), repeating
    write_slot(1, pack_time(0, 0, 0, 2, 0, 0, 0), 7'b0001000, 1'b1, 1'b1);
    tick(pack_time(17, 44, 9, 2, 13, 7, 40), 2'b00);
    expect_item(0, 2, 0, "R4 slot 1 fires alone, R2 other fields ignored");
    tick(pack_time(18, 44, 9, 2, 13, 7, 40), 2'b10);
    expect_item(0, 2, 0, "R5 firing wins over same-cycle clear");
    clear(2'b10);
    expect_item(0, 0, 0, "R5 slot 1 cleared");
    tick(pack_time(19, 44, 9, 2, 13, 7, 40), 2'b00);
    expect_item(0, 2, 0, "R7 repeating slot fires again");
    tick(pack_time(20, 44, 9, 3, 13, 7, 40), 2'b10);
    expect_item(0, 0, 0, "R2 dow mismatch, no fire");

    // slot 0: exact date and time, all fields enabled
    write_slot(0, full_t, 7'h7f, 1'b1, 1'b0);
    tick(pack_time(0, 23, 5, 2, 21, 3, 27), 2'b00);
    expect_item(0, 2, 0, "R2 year off by one, slot 0 silent");
    tick(full_t, 2'b00);
    expect_item(0, 3, 0, "R4 both slots fire on same tick");
    clear(2'b11);
    expect_item(0, 0, 0, "R5 both flags cleared");

    write_slot(0, full_t, 7'h7f, 1'b0, 1'b0);
    tick(full_t, 2'b00);
    expect_item(0, 2, 0, "R11 disarmed slot 0 ignores full match");

    out_mode = 3'd0;
    idle(2);
    expect_item(1, 1, 0, "R10 off mode pin high with flag set");
    out_mode = 3'd6;
    idle(2);
    expect_item(1, 1, 0, "R10 unused code pin high");
    out_mode = 3'd1;
    idle(2);
    expect_item(1, 0, 0, "R8 interrupt mode pin low");

    xtal_run = 1;
    out_mode = 3'd4;
    idle(4);
    mism = 0;
    for (int k = 0; k < 24; k++) begin
      @(posedge clk);
      xs = xtal_in;
      @(negedge clk);
      if (irq_fout_n !== xs) mism++;
    end
    expect_item(2, 0, mism, "R9 32768 Hz mode follows reference");

    out_mode = 3'd3;
    idle(4);
    count_rises(256, rises);
    expect_item(2, 8, rises, "R9 4096 Hz rising edges in 64 reference cycles");

    out_mode = 3'd2;
    idle(4);
    count_rises(256, rises);
    expect_item(2, 2, rises, "R9 slow wave rising edges in 64 reference cycles");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule